// File: doc/BRIEF.md
# GPIO Interrupt Channel Router

This block picks a few interrupt channels out of a wide vector of GPIO pad inputs and hands them to a downstream interrupt controller. The pads pass through a two-flop synchroniser. Each channel then picks one pad, can invert it, and can apply a glitch filter. The channel delivers the result either as a level or as a one-cycle pulse on a rising edge. With these controls, active-low levels and falling edges reach the downstream side as active-high levels and rising edges. The downstream controller therefore only ever has to handle one polarity per signalling kind.

Software sets up the block through a small word-addressed register port: write and read strobes, a word address and 32-bit data. Read data is registered and appears in the cycle after the read strobe. A channel handles one polarity at a time: it cannot trigger on both edges.

Top module: `pad_irq_router`

## Requirements
- R1: After reset, every configuration word reads zero and every irq_out bit is low.
- R2: Word 1 holds the 8-bit pad selects of channels 0 to 3, and word 2 holds those of channels 4 to 7. Channel n's select sits at bit (n mod 4)*8 of its word. All 32 bits of each word read back as written.
- R3: In word 0, bit n is channel n's edge-mode bit and bit 16+n is its invert bit. Bits 8 to 15 and 24 to 31 are not stored and read zero.
- R4: Word 3 holds a 4-bit filter length for each channel, at bit n*4. It reads back as written.
- R5: A read of word 4 or above returns zero. Read data is valid in the cycle after the read strobe.
- R6: In level mode with no inversion and a filter length of 0 or 1, a pad change appears at irq_out on the third rising clock edge after it.
- R7: With the invert bit set, the selected pad is inverted before filtering, so a low pad gives a high level or a rising edge.
- R8: In edge mode, a channel drives a single-cycle pulse when its accepted signal goes from low to high. It does not pulse on a falling edge.
- R9: With a filter length N of 2 or more, the synchronised input must differ from the accepted state for N consecutive cycles before the accepted state changes. A shorter glitch never reaches irq_out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| pads | input | NUM_PADS | GPIO pad inputs, asynchronous |
| irq_out | output | NUM_CH | Conditioned interrupt line per channel |

## Verification
Any wrong filter count or stale accepted state shows at irq_out. It appears as a level change or pulse that comes one or more cycles early or late, or that is missing or extra. It becomes visible within at most two plus the filter length cycles of the pad edge that should have triggered it. A wrong previous-state flop in edge mode shows as a pulse lasting two cycles, or as a pulse on a falling edge, in the very next cycle. A corrupted configuration field shows at reg_rdata one cycle after the read strobe. It also shows as the wrong pad or the wrong polarity steering the channel's output. The bench compares every channel in every cycle against a model built from the requirements. Meanwhile it toggles a small pad group and rewrites the configuration at random.

// File: rtl/pir_pkg.sv
package pir_pkg;
  localparam int NUM_CH  = 8;
  localparam int SEL_W   = 8;
  localparam int FILT_W  = 4;
  localparam int DATA_W  = 32;

  localparam int W_MODE  = 0;
  localparam int W_SEL_A = 1;
  localparam int W_SEL_B = 2;
  localparam int W_FILT  = 3;

  localparam logic [DATA_W-1:0] MODE_MASK = 32'h00FF_00FF;

  typedef struct packed {
    logic [SEL_W-1:0]  sel;
    logic              edge_en;
    logic              inv;
    logic [FILT_W-1:0] flen;
  } chan_cfg_t;
endpackage

// File: rtl/pir_regs.sv
module pir_regs
  import pir_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_i,
  input  logic                         rd_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [DATA_W-1:0]            wdata_i,
  output logic [DATA_W-1:0]            rdata_o,
  output chan_cfg_t [NUM_CH-1:0]       cfg_o
);
  logic [DATA_W-1:0] mode_q, sela_q, selb_q, filt_q;
  logic [DATA_W-1:0] mode_d, sela_d, selb_d, filt_d, rdata_d;
  logic              mode_en, sela_en, selb_en, filt_en;

  assign mode_en = wr_i && (32'(addr_i) == W_MODE);
  assign sela_en = wr_i && (32'(addr_i) == W_SEL_A);
  assign selb_en = wr_i && (32'(addr_i) == W_SEL_B);
  assign filt_en = wr_i && (32'(addr_i) == W_FILT);

  always_comb begin
    mode_d = wdata_i & MODE_MASK;
    sela_d = wdata_i;
    selb_d = wdata_i;
    filt_d = wdata_i;
    case (32'(addr_i))
      W_MODE:  rdata_d = mode_q;
      W_SEL_A: rdata_d = sela_q;
      W_SEL_B: rdata_d = selb_q;
      W_FILT:  rdata_d = filt_q;
      default: rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      sela_q  <= '0;
      selb_q  <= '0;
      filt_q  <= '0;
      rdata_o <= '0;
    end else begin
      if (mode_en) mode_q  <= mode_d;
      if (sela_en) sela_q  <= sela_d;
      if (selb_en) selb_q  <= selb_d;
      if (filt_en) filt_q  <= filt_d;
      if (rd_i)    rdata_o <= rdata_d;
    end
  end

  for (genvar n = 0; n < NUM_CH; n++) begin : g_cfg
    localparam int SH = (n % 4) * SEL_W;
    if (n < 4) begin : g_lo
      assign cfg_o[n].sel = sela_q[SH +: SEL_W];
    end else begin : g_hi
      assign cfg_o[n].sel = selb_q[SH +: SEL_W];
    end
    assign cfg_o[n].edge_en = mode_q[n];
    assign cfg_o[n].inv     = mode_q[16 + n];
    assign cfg_o[n].flen    = filt_q[n*FILT_W +: FILT_W];
  end

  p_unmapped_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && 32'(addr_i) > W_FILT) |=> (rdata_o == '0));

  p_mode_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mode_en |=> (mode_q == ($past(wdata_i) & MODE_MASK)));

  p_sel_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sela_en |=> (sela_q == $past(wdata_i)));
endmodule

// File: rtl/pir_sync.sv
module pir_sync #(
  parameter int WIDTH = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_o <= '0;
    end else begin
      meta_q <= async_i;
      sync_o <= meta_q;
    end
  end

  p_two_stage_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (sync_o == $past(meta_q)));
endmodule

// File: rtl/pir_channel.sv
module pir_channel
  import pir_pkg::*;
#(
  parameter int NUM_PADS = 256
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PADS-1:0] pads_i,
  input  chan_cfg_t           cfg_i,
  output logic                irq_o
);
  localparam int IDX_W = (NUM_PADS > 1) ? $clog2(NUM_PADS) : 1;

  logic              picked, raw;
  logic              acc_q, acc_d, prev_q;
  logic [FILT_W-1:0] cnt_q, cnt_d;
  logic [FILT_W:0]   cnt_inc;

  assign picked  = (32'(cfg_i.sel) < NUM_PADS) ? pads_i[cfg_i.sel[IDX_W-1:0]] : 1'b0;
  assign raw     = picked ^ cfg_i.inv;
  assign cnt_inc = {1'b0, cnt_q} + 1'b1;

  always_comb begin
    acc_d = acc_q;
    cnt_d = '0;
    if (raw != acc_q) begin
      if (cnt_inc >= {1'b0, cfg_i.flen}) begin
        acc_d = raw;
      end else begin
        cnt_d = cnt_inc[FILT_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= 1'b0;
      cnt_q  <= '0;
      prev_q <= 1'b0;
    end else begin
      acc_q  <= acc_d;
      cnt_q  <= cnt_d;
      prev_q <= acc_q;
    end
  end

  assign irq_o = cfg_i.edge_en ? (acc_q & ~prev_q) : acc_q;

  p_accept_follows_input_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(acc_q) |-> (acc_q == $past(raw)));

  p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_i.edge_en && irq_o) |=> (!cfg_i.edge_en || !irq_o));

  p_no_fall_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_i.edge_en && irq_o) |-> acc_q);
endmodule

// File: rtl/pad_irq_router.sv
module pad_irq_router
  import pir_pkg::*;
#(
  parameter int NUM_PADS = 256,
  parameter int ADDR_W   = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  input  logic [NUM_PADS-1:0] pads,
  output logic [NUM_CH-1:0]   irq_out
);
  logic [1:0]             rst_pipe_q;
  logic                   rst_int_n;
  logic [NUM_PADS-1:0]    pads_sync;
  chan_cfg_t [NUM_CH-1:0] cfg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  pir_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_int_n), .wr_i(reg_wr), .rd_i(reg_rd),
    .addr_i(reg_addr), .wdata_i(reg_wdata), .rdata_o(reg_rdata), .cfg_o(cfg)
  );

  pir_sync #(.WIDTH(NUM_PADS)) u_sync (
    .clk(clk), .rst_n(rst_int_n), .async_i(pads), .sync_o(pads_sync)
  );

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    pir_channel #(.NUM_PADS(NUM_PADS)) u_ch (
      .clk(clk), .rst_n(rst_int_n), .pads_i(pads_sync),
      .cfg_i(cfg[n]), .irq_o(irq_out[n])
    );
  end

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_int_n |-> (irq_out == '0));
endmodule

// File: tb/pad_irq_router_bench.sv
module pad_irq_router_bench;
  localparam int NP = 256;
  localparam int NC = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [NP-1:0] pads = '0;
  logic [NC-1:0] irq_out;

  int checks = 0, errors = 0, cycles = 0;
  bit cmp_en = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pad_irq_router u_pad_irq_router (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pads(pads), .irq_out(irq_out)
  );

  // reference model built from the requirements
  logic [31:0]   m_mode = '0, m_sela = '0, m_selb = '0, m_filt = '0;
  logic [NP-1:0] m_s1 = '0, m_s2 = '0;
  logic [NC-1:0] m_acc = '0, m_prev = '0;
  logic [3:0]    m_cnt [NC];

  initial for (int i = 0; i < NC; i++) m_cnt[i] = '0;

  function automatic logic [7:0] m_sel(int n);
    return (n < 4) ? m_sela[(n%4)*8 +: 8] : m_selb[(n%4)*8 +: 8];
  endfunction

  function automatic logic m_exp(int n);
    return m_mode[n] ? (m_acc[n] & ~m_prev[n]) : m_acc[n];
  endfunction

  always @(posedge clk) begin
    if (rst_n) begin
      if (reg_wr) begin
        case (reg_addr)
          4'd0: m_mode <= reg_wdata & 32'h00FF00FF;
          4'd1: m_sela <= reg_wdata;
          4'd2: m_selb <= reg_wdata;
          4'd3: m_filt <= reg_wdata;
          default: ;
        endcase
      end
      m_s1 <= pads;
      m_s2 <= m_s1;
      m_prev <= m_acc;
      for (int n = 0; n < NC; n++) begin
        logic r;
        int   len;
        r   = m_s2[m_sel(n)] ^ m_mode[16+n];
        len = int'(m_filt[n*4 +: 4]);
        if (r == m_acc[n]) m_cnt[n] <= '0;
        else if (int'(m_cnt[n]) + 1 >= len) begin
          m_acc[n] <= r;
          m_cnt[n] <= '0;
        end else m_cnt[n] <= m_cnt[n] + 1'b1;
      end
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en) begin
      for (int n = 0; n < NC; n++) begin
        string tag;
        if (m_mode[n])                      tag = "R8 edge";
        else if (m_filt[n*4 +: 4] > 4'd1)   tag = "R9 filter";
        else if (m_mode[16+n])              tag = "R7 invert";
        else                                tag = "R6 level";
        check($sformatf("%s ch%0d", tag, n), 32'(irq_out[n]), 32'(m_exp(n)));
      end
    end
  end

  task automatic wr(int a, logic [31:0] d);
    reg_addr = 4'(a); reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(string tag, int a, logic [31:0] exp);
    reg_addr = 4'(a); reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    check(tag, reg_rdata, exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=<150000", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 irq after reset", 32'(irq_out), 32'h0);
    for (int a = 0; a < 4; a++) rd_chk("R1 config after reset", a, 32'h0);

    // register layout
    wr(0, 32'hFFFF_FFFF);
    rd_chk("R3 mode word masks unused bits", 0, 32'h00FF_00FF);
    wr(1, 32'h4433_2211);
    rd_chk("R2 select word channels 0-3", 1, 32'h4433_2211);
    wr(2, 32'h8877_6655);
    rd_chk("R2 select word channels 4-7", 2, 32'h8877_6655);
    wr(3, 32'hFEDC_BA98);
    rd_chk("R4 filter word", 3, 32'hFEDC_BA98);
    wr(4, 32'h1234_5678);
    rd_chk("R5 unmapped word 4", 4, 32'h0);
    rd_chk("R5 unmapped word 15", 15, 32'h0);
    rd_chk("R5 mode unchanged by unmapped write", 0, 32'h00FF_00FF);

    // directed R6 latency: ch0 on pad 5, level, no filter
    wr(0, 32'h0); wr(1, 32'h0000_0005); wr(2, 32'h0); wr(3, 32'h0);
    repeat (4) @(negedge clk);
    pads[5] = 1'b1;
    @(negedge clk); check("R6 latency edge1", 32'(irq_out[0]), 32'h0);
    @(negedge clk); check("R6 latency edge2", 32'(irq_out[0]), 32'h0);
    @(negedge clk); check("R6 latency edge3", 32'(irq_out[0]), 32'h1);
    pads[5] = 1'b0;
    repeat (4) @(negedge clk);

    // directed R7: invert ch0, low pad gives high
    wr(0, 32'h0001_0000);
    repeat (4) @(negedge clk);
    check("R7 inverted low pad", 32'(irq_out[0]), 32'h1);

    // directed R9: filter 3, 2-cycle glitch is dropped
    wr(0, 32'h0); wr(3, 32'h0000_0003);
    repeat (5) @(negedge clk);
    pads[5] = 1'b1; repeat (2) @(negedge clk); pads[5] = 1'b0;
    for (int i = 0; i < 8; i++) begin
      check("R9 short glitch blocked", 32'(irq_out[0]), 32'h0);
      @(negedge clk);
    end

    // directed R8: edge mode, one pulse on rise, none on fall
    wr(3, 32'h0); wr(0, 32'h0000_0001);
    repeat (4) @(negedge clk);
    pads[5] = 1'b1;
    repeat (2) @(negedge clk);
    check("R8 no pulse yet", 32'(irq_out[0]), 32'h0);
    @(negedge clk); check("R8 pulse", 32'(irq_out[0]), 32'h1);
    @(negedge clk); check("R8 pulse ends", 32'(irq_out[0]), 32'h0);
    pads[5] = 1'b0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); check("R8 no pulse on fall", 32'(irq_out[0]), 32'h0);
    end

    // random phase against the model
    void'($urandom(32'd1234));
    cmp_en = 1'b1;
    for (int it = 0; it < 4000; it++) begin
      if ($urandom_range(0, 49) == 0) begin
        int a;
        logic [31:0] d;
        a = $urandom_range(0, 4);
        case (a)
          1, 2: d = {4'h0, 4'($urandom), 4'h0, 4'($urandom),
                     4'h0, 4'($urandom), 4'h0, 4'($urandom)};
          3: begin
            d = '0;
            for (int n = 0; n < 8; n++) d[n*4 +: 4] = 4'($urandom_range(0, 5));
          end
          default: d = $urandom;
        endcase
        wr(a, d);
      end else begin
        for (int p = 0; p < 16; p++)
          if ($urandom_range(0, 5) == 0) pads[p] = ~pads[p];
        @(negedge clk);
      end
    end
    cmp_en = 1'b0;
    finish_run();
  end
endmodule